// File: doc/BRIEF.md
# Random Number Generator Control and Status Front End

This block sits between a simple 32-bit register bus and a random word source. Software reaches six registers through it: a read-only identity word, a command register of self-clearing action bits, a control register of enables and interrupt masks, a status word, an error code word and an output port that yields one random word per read. The block sequences two timed operations, a self-test and a seed generation. Each operation, when it finishes, raises its own completion flag. A failed statistical check raises an error. A single interrupt line is driven from those flags through the masks.

The random source is a free-running 32-bit LFSR stub. Each successful seed stirs it. It feeds an output queue of up to 15 words, and the queue is topped up only after a seed has succeeded. An input pin forces the statistical check to fail, so that the error path can be exercised. An optional automatic mode starts a fresh seed once a programmed number of words has been read out. An error latches. While an error is pending, the ordinary interrupt clear has no effect, and only the dedicated clear-error command removes it.

Top module: `rngc_top`

## Requirements
- R1: A read of offset 0x00 returns the type code in bits 31:28, the major revision in bits 15:8 and the minor revision in bits 7:0, with all other bits zero (0x20000301 for the default parameters).
- R2: The control register at 0x08 stores bit 4 (automatic reseed), bit 5 (mask completion interrupt) and bit 6 (mask error interrupt), and reads all other bits as zero. Writes to offsets 0x00, 0x0C and 0x10 change nothing.
- R3: The command register at 0x04 always reads as zero. Its bits act only in the cycle they are written.
- R4: Writing command bit 0 while idle starts a self-test. After TEST_CYCLES cycles, status bit 4 (self-test complete) is set.
- R5: Writing command bit 1 while idle starts a seed. After SEED_CYCLES cycles, status bit 5 (seed complete) is set. After a successful seed, the queue fills to 15 words, and status bits 11:8 report the fill level. Status reads 0 after reset.
- R6: Each read of 0x14 removes one word from the queue and returns it, and the word is never zero. A read while the queue is empty returns zero. It also sets status bit 16 and error-code bit 0, so the error register reads 0x1.
- R7: A start command written while an operation is running is ignored. When bits 0 and 1 are written together while idle, the self-test runs and the seed does not.
- R8: Command bit 4 clears both completion flags, but only when no error is pending. Command bit 5 clears the error code, status bit 16 and both completion flags.
- R9: irq is high exactly when (a completion flag is set and control bit 5 is clear) or (the error flag is set and control bit 6 is clear).
- R10: If the statistical check fails at the end of an operation, bit 3 of the error register is set (value 0x8 alone). After a failed seed, the queue is not refilled until a later seed succeeds.
- R11: With control bit 4 set, a seed starts by itself once RESEED_WORDS words have been read since the last seed started. It does not start after fewer reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| statFailInj | input | 1 | Test hook: forces the statistical check to fail |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest states to reach are those where the queue level must be seen falling. The queue tops itself up every idle cycle, so its level drops only while an operation holds filling off. The bench therefore starts a seed and makes a random number of reads inside that seed window. It then checks the level before the window closes. The no-refill rule after a failed seed is reached by driving the failure hook, draining the queue and waiting well past any refill time. The reseed counter is checked at one word below its threshold and then at the threshold.

// File: rtl/rngc_pkg.sv
`timescale 1ns/1ps
package rngc_pkg;
  localparam int BUS_W = 32;

  // register byte offsets
  localparam logic [7:0] REG_VER  = 8'h00;
  localparam logic [7:0] REG_CMD  = 8'h04;
  localparam logic [7:0] REG_CTL  = 8'h08;
  localparam logic [7:0] REG_STAT = 8'h0C;
  localparam logic [7:0] REG_ERR  = 8'h10;
  localparam logic [7:0] REG_FIFO = 8'h14;

  // command bits
  localparam int CMD_TEST   = 0;
  localparam int CMD_SEED   = 1;
  localparam int CMD_CLRINT = 4;
  localparam int CMD_CLRERR = 5;

  // control bits
  localparam int CTL_AUTO  = 4;
  localparam int CTL_MDONE = 5;
  localparam int CTL_MERR  = 6;

  // status bits
  localparam int ST_TDONE  = 4;
  localparam int ST_SDONE  = 5;
  localparam int ST_LVL_LO = 8;
  localparam int ST_ERR    = 16;

  // error code bits
  localparam int ERR_EMPTY = 0;
  localparam int ERR_STAT  = 3;

  typedef enum logic [1:0] {OP_IDLE, OP_SEED, OP_TEST} opState_e;

  typedef struct packed {
    logic pop;
    logic fillEn;
    logic reseed;
  } dpStrobe_t;
endpackage

// File: rtl/rngc_datapath.sv
`timescale 1ns/1ps
module rngc_datapath
  import rngc_pkg::*;
#(
  parameter int              DEPTH     = 15,
  parameter int              LVL_W     = 4,
  parameter logic [BUS_W-1:0] LFSR_POLY = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic [LVL_W-1:0] level,
  output logic [BUS_W-1:0] headWord
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [BUS_W-1:0] LFSR_INIT = 32'h1ACE_B00C;

  logic [BUS_W-1:0] lfsr;
  logic [BUS_W-1:0] mixCnt;
  logic [BUS_W-1:0] stepped;
  logic [BUS_W-1:0] stirred;
  logic [BUS_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush;

  function automatic logic [BUS_W-1:0] lfsrStep(input logic [BUS_W-1:0] x);
    return x[0] ? ((x >> 1) ^ LFSR_POLY) : (x >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign stepped = lfsrStep(lfsr);
  assign stirred = stepped ^ mixCnt;
  assign doPush  = strobe.fillEn && (level < LVL_W'(DEPTH));

  // entropy stub: free running LFSR, stirred on each good seed
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr   <= LFSR_INIT;
      mixCnt <= '0;
    end else begin
      mixCnt <= mixCnt + 1'b1;
      if (strobe.reseed)
        lfsr <= (stirred == '0) ? BUS_W'(1) : stirred;
      else
        lfsr <= stepped;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= lfsr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= ptrNext(wrPtr);
      if (strobe.pop) rdPtr <= ptrNext(rdPtr);
      case ({doPush, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headWord = mem[rdPtr];
endmodule

// File: rtl/rngc_ctrl.sv
`timescale 1ns/1ps
module rngc_ctrl
  import rngc_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         LVL_W        = 4,
  parameter int         SEED_CYCLES  = 64,
  parameter int         TEST_CYCLES  = 32,
  parameter int         RESEED_WORDS = 5 * (1 << 20),
  parameter logic [3:0] VER_TYPE     = 4'd2,
  parameter logic [7:0] VER_MAJ      = 8'd3,
  parameter logic [7:0] VER_MIN      = 8'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busRdEn,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              statFailInj,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic [BUS_W-1:0]  fifoHead,
  output dpStrobe_t         strobe,
  output logic              irq,
  output logic              errFlag,
  output logic              opBusy,
  output logic [1:0]        doneBits
);
  localparam int OP_MAX = (SEED_CYCLES > TEST_CYCLES) ? SEED_CYCLES : TEST_CYCLES;
  localparam int OPC_W  = $clog2(OP_MAX + 1);
  localparam int WC_W   = $clog2(RESEED_WORDS + 1);

  opState_e         opState;
  logic [OPC_W-1:0] opCnt;
  logic [WC_W-1:0]  wordCnt;
  logic             ctrlAuto, maskDone, maskErr;
  logic             testDone, seedDone, errStat, errEmpty, seeded;
  logic             cmdWr, ctlWr, fifoRd, popOk, emptyRd, idle;
  logic             startTest, startSeed, autoTrig, opEnd, seedEnd, testEnd;
  logic             clrErrCmd, clrIntCmd;
  logic [OPC_W-1:0] curLast;
  logic [BUS_W-1:0] rdMux;

  assign idle      = (opState == OP_IDLE);
  assign cmdWr     = busWrEn && (busAddr == ADDR_W'(REG_CMD));
  assign ctlWr     = busWrEn && (busAddr == ADDR_W'(REG_CTL));
  assign fifoRd    = busRdEn && (busAddr == ADDR_W'(REG_FIFO));
  assign popOk     = fifoRd && (fifoLevel != '0);
  assign emptyRd   = fifoRd && (fifoLevel == '0);
  assign errFlag   = errStat | errEmpty;
  assign autoTrig  = ctrlAuto && (wordCnt >= WC_W'(RESEED_WORDS));
  assign startTest = idle && cmdWr && busWrData[CMD_TEST];
  assign startSeed = idle && !startTest && ((cmdWr && busWrData[CMD_SEED]) || autoTrig);
  assign curLast   = (opState == OP_SEED) ? OPC_W'(SEED_CYCLES - 1) : OPC_W'(TEST_CYCLES - 1);
  assign opEnd     = !idle && (opCnt == curLast);
  assign seedEnd   = opEnd && (opState == OP_SEED);
  assign testEnd   = opEnd && (opState == OP_TEST);
  assign clrErrCmd = cmdWr && busWrData[CMD_CLRERR];
  assign clrIntCmd = cmdWr && busWrData[CMD_CLRINT] && !errFlag;

  // operation sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opState <= OP_IDLE;
      opCnt   <= '0;
    end else if (startTest) begin
      opState <= OP_TEST;
      opCnt   <= '0;
    end else if (startSeed) begin
      opState <= OP_SEED;
      opCnt   <= '0;
    end else if (opEnd) begin
      opState <= OP_IDLE;
    end else if (!idle) begin
      opCnt <= opCnt + 1'b1;
    end
  end

  // completion and error flags: a setting event wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      testDone <= 1'b0;
      seedDone <= 1'b0;
      errStat  <= 1'b0;
      errEmpty <= 1'b0;
      seeded   <= 1'b0;
    end else begin
      if (clrErrCmd) begin
        testDone <= 1'b0;
        seedDone <= 1'b0;
        errStat  <= 1'b0;
        errEmpty <= 1'b0;
      end else if (clrIntCmd) begin
        testDone <= 1'b0;
        seedDone <= 1'b0;
      end
      if (seedEnd) begin
        seedDone <= 1'b1;
        seeded   <= !statFailInj;
        if (statFailInj) errStat <= 1'b1;
      end
      if (testEnd) begin
        testDone <= 1'b1;
        if (statFailInj) errStat <= 1'b1;
      end
      if (emptyRd) errEmpty <= 1'b1;
    end
  end

  // words served since the last seed started
  always_ff @(posedge clk) begin
    if (!rstN)
      wordCnt <= '0;
    else if (startSeed)
      wordCnt <= '0;
    else if (popOk && (wordCnt < WC_W'(RESEED_WORDS)))
      wordCnt <= wordCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlAuto <= 1'b0;
      maskDone <= 1'b0;
      maskErr  <= 1'b0;
    end else if (ctlWr) begin
      ctrlAuto <= busWrData[CTL_AUTO];
      maskDone <= busWrData[CTL_MDONE];
      maskErr  <= busWrData[CTL_MERR];
    end
  end

  always_comb begin
    rdMux = '0;
    case (busAddr)
      ADDR_W'(REG_VER): begin
        rdMux[31:28] = VER_TYPE;
        rdMux[15:8]  = VER_MAJ;
        rdMux[7:0]   = VER_MIN;
      end
      ADDR_W'(REG_CTL): begin
        rdMux[CTL_AUTO]  = ctrlAuto;
        rdMux[CTL_MDONE] = maskDone;
        rdMux[CTL_MERR]  = maskErr;
      end
      ADDR_W'(REG_STAT): begin
        rdMux[ST_TDONE]              = testDone;
        rdMux[ST_SDONE]              = seedDone;
        rdMux[ST_LVL_LO +: LVL_W]    = fifoLevel;
        rdMux[ST_ERR]                = errFlag;
      end
      ADDR_W'(REG_ERR): begin
        rdMux[ERR_EMPTY] = errEmpty;
        rdMux[ERR_STAT]  = errStat;
      end
      ADDR_W'(REG_FIFO): rdMux = (fifoLevel != '0) ? fifoHead : '0;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busRdData <= '0;
    else if (busRdEn) busRdData <= rdMux;
  end

  assign strobe.pop    = popOk;
  assign strobe.fillEn = seeded && idle;
  assign strobe.reseed = seedEnd && !statFailInj;

  assign irq      = ((testDone | seedDone) & ~maskDone) | (errFlag & ~maskErr);
  assign opBusy   = !idle;
  assign doneBits = {seedDone, testDone};
endmodule

// File: rtl/rngc_top.sv
`timescale 1ns/1ps
module rngc_top
  import rngc_pkg::*;
#(
  parameter int               ADDR_W       = 8,
  parameter int               FIFO_DEPTH   = 15,
  parameter int               SEED_CYCLES  = 64,
  parameter int               TEST_CYCLES  = 32,
  parameter int               RESEED_WORDS = 5 * (1 << 20),
  parameter logic [3:0]       VER_TYPE     = 4'd2,
  parameter logic [7:0]       VER_MAJ      = 8'd3,
  parameter logic [7:0]       VER_MIN      = 8'd1,
  parameter logic [31:0]      LFSR_POLY    = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  input  logic              statFailInj,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  dpStrobe_t        strobe;
  logic [LVL_W-1:0] fifoLevel;
  logic [31:0]      fifoHead;
  logic             errFlag;
  logic             opBusy;
  logic [1:0]       doneBits;

  rngc_ctrl #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .SEED_CYCLES(SEED_CYCLES),
    .TEST_CYCLES(TEST_CYCLES), .RESEED_WORDS(RESEED_WORDS),
    .VER_TYPE(VER_TYPE), .VER_MAJ(VER_MAJ), .VER_MIN(VER_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .statFailInj(statFailInj), .fifoLevel(fifoLevel), .fifoHead(fifoHead),
    .strobe(strobe), .irq(irq), .errFlag(errFlag), .opBusy(opBusy),
    .doneBits(doneBits)
  );

  rngc_datapath #(
    .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .LFSR_POLY(LFSR_POLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .level(fifoLevel), .headWord(fifoHead)
  );
endmodule

// File: rtl/rngc_checker.sv
`timescale 1ns/1ps
module rngc_checker #(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 4,
  parameter int DEPTH  = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic              busRdEn,
  input logic [31:0]       busRdData,
  input logic              irq,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              errFlag,
  input logic              opBusy,
  input logic [1:0]        doneBits
);
  logic cmdWr;
  assign cmdWr = busWrEn && (busAddr == ADDR_W'(8'h04));

  assert_cmd_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(8'h04)) |=> (busRdData == 32'h0));

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(8'h14) && fifoLevel == '0)
      |=> (busRdData == 32'h0 && errFlag));

  assert_clrint_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWrData[4] && !busWrData[5] && errFlag && !opBusy)
      |=> ($stable(doneBits) && errFlag));

  assert_clrerr_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWrData[5] && !opBusy && !busRdEn) |=> (!errFlag && !irq));
endmodule

bind rngc_top rngc_checker #(
  .ADDR_W(ADDR_W), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
  .irq(irq), .fifoLevel(fifoLevel), .errFlag(errFlag), .opBusy(opBusy),
  .doneBits(doneBits)
);

// File: tb/rngc_top_test.sv
`timescale 1ns/1ps
module rngc_top_test;
  localparam int SEEDC   = 12;
  localparam int TESTC   = 6;
  localparam int RESEEDW = 8;
  localparam int DEPTH   = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        statFailInj = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rngc_top #(
    .ADDR_W(8), .FIFO_DEPTH(DEPTH), .SEED_CYCLES(SEEDC),
    .TEST_CYCLES(TESTC), .RESEED_WORDS(RESEEDW)
  ) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .statFailInj(statFailInj), .irq(irq)
  );

  function automatic logic [31:0] statusWord(input bit tDone, input bit sDone,
                                             input int lvl, input bit err);
    logic [31:0] w = '0;
    w[4] = tDone;
    w[5] = sDone;
    w[11:8] = 4'(lvl);
    w[16] = err;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] prev;
    int unused;
    unused = $urandom(20240611);
    waitCycles(4);
    rstN = 1'b1;

    // R1 identity word, R5 reset status, R9 reset irq
    busRead(8'h00, d);   check("R1 version", d, 32'h2000_0301);
    busRead(8'h0C, d);   check("R5 reset status", d, 32'h0);
    check("R9 reset irq", {31'h0, irq}, 32'h0);

    // R2 control storage and read-only offsets
    busWrite(8'h08, 32'hFFFF_FFFF);
    busRead(8'h08, d);   check("R2 control bits", d, 32'h70);
    busWrite(8'h08, 32'h0);
    busWrite(8'h0C, $urandom);
    busWrite(8'h10, $urandom);
    busWrite(8'h00, $urandom);
    busRead(8'h0C, d);   check("R2 status not writable", d, 32'h0);
    busRead(8'h10, d);   check("R2 error not writable", d, 32'h0);
    busRead(8'h00, d);   check("R2 version not writable", d, 32'h2000_0301);

    // R6 empty read
    busRead(8'h14, d);   check("R6 empty read data", d, 32'h0);
    busRead(8'h0C, d);   check("R6 empty read status", d, statusWord(0, 0, 0, 1));
    busRead(8'h10, d);   check("R6 empty read code", d, 32'h1);
    check("R9 irq on error", {31'h0, irq}, 32'h1);

    // R8 clear-int held off by error, clear-error works
    busWrite(8'h04, 32'h10);
    busRead(8'h0C, d);   check("R8 clear-int with error", d, statusWord(0, 0, 0, 1));
    busWrite(8'h04, 32'h20);
    busRead(8'h0C, d);   check("R8 clear-error status", d, 32'h0);
    check("R8 clear-error irq", {31'h0, irq}, 32'h0);

    // R4 self-test, R3 command readback, R9 masking
    busWrite(8'h04, 32'h1);
    busRead(8'h04, d);   check("R3 command reads zero", d, 32'h0);
    waitCycles(TESTC + 2);
    busRead(8'h0C, d);   check("R4 self-test done", d, statusWord(1, 0, 0, 0));
    check("R9 irq on done", {31'h0, irq}, 32'h1);
    busWrite(8'h08, 32'h20);
    check("R9 done masked", {31'h0, irq}, 32'h0);
    busWrite(8'h08, 32'h0);
    check("R9 done unmasked", {31'h0, irq}, 32'h1);
    busWrite(8'h04, 32'h10);
    busRead(8'h0C, d);   check("R8 clear-int clears done", d, 32'h0);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);

    // R7 start while busy ignored, R5 seed and fill
    busWrite(8'h04, 32'h2);
    busWrite(8'h04, 32'h1);
    waitCycles(SEEDC + 2);
    busRead(8'h0C, d);   check("R7 busy start ignored", d & 32'h30, 32'h20);
    waitCycles(20);
    busRead(8'h0C, d);   check("R5 queue full", d, statusWord(0, 1, DEPTH, 0));

    // R7 priority of self-test over seed
    busWrite(8'h04, 32'h10);
    busWrite(8'h04, 32'h3);
    waitCycles(TESTC + 2);
    busRead(8'h0C, d);   check("R7 test priority", d & 32'h30, 32'h10);
    busWrite(8'h04, 32'h10);

    // R6 pops inside a seed window, random counts
    for (int k = 0; k < 3; k++) begin
      int n;
      n = $urandom_range(1, 4);
      busWrite(8'h04, 32'h2);
      prev = '0;
      for (int i = 0; i < n; i++) begin
        busRead(8'h14, d);
        check("R6 word nonzero", {31'h0, d != 0}, 32'h1);
        check("R6 words differ", {31'h0, d != prev}, 32'h1);
        prev = d;
      end
      busRead(8'h0C, d);  check("R6 level after pops", {28'h0, d[11:8]}, 32'(DEPTH - n));
      waitCycles(SEEDC + 20);
      busRead(8'h0C, d);  check("R5 refilled", d, statusWord(0, 1, DEPTH, 0));
      busWrite(8'h04, 32'h10);
    end

    // R10 statistical failure
    statFailInj = 1'b1;
    busWrite(8'h04, 32'h2);
    waitCycles(SEEDC + 2);
    busRead(8'h10, d);   check("R10 stat code", d, 32'h8);
    busRead(8'h0C, d);   check("R10 status", d, statusWord(0, 1, DEPTH, 1));
    check("R9 irq on stat fail", {31'h0, irq}, 32'h1);
    busWrite(8'h08, 32'h40);
    check("R9 error masked done open", {31'h0, irq}, 32'h1);
    busWrite(8'h08, 32'h60);
    check("R9 both masked", {31'h0, irq}, 32'h0);
    for (int i = 0; i < DEPTH; i++) busRead(8'h14, d);
    waitCycles(20);
    busRead(8'h0C, d);   check("R10 no refill", d, statusWord(0, 1, 0, 1));
    busRead(8'h14, d);   check("R6 drained read", d, 32'h0);
    busRead(8'h10, d);   check("R10 combined code", d, 32'h9);
    statFailInj = 1'b0;
    busWrite(8'h04, 32'h20);
    busWrite(8'h08, 32'h0);
    busWrite(8'h04, 32'h2);
    waitCycles(SEEDC + 20);
    busRead(8'h0C, d);   check("R10 recovery seed", d, statusWord(0, 1, DEPTH, 0));

    // R11 automatic reseed threshold
    busWrite(8'h04, 32'h10);
    busWrite(8'h08, 32'h10);
    for (int i = 0; i < RESEEDW - 1; i++) busRead(8'h14, d);
    waitCycles(30);
    busRead(8'h0C, d);   check("R11 below threshold", d, statusWord(0, 0, DEPTH, 0));
    busRead(8'h14, d);
    waitCycles(SEEDC + 20);
    busRead(8'h0C, d);   check("R11 auto seed", d, statusWord(0, 1, DEPTH, 0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule